// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block keeps the tag and permission state for a set-associative cache whose data lives elsewhere. Each request carries a line-aligned address and a command. The block selects a set from a fixed address field and compares the line address against every way of that set in parallel. For an access it reports hit, the matching way and whether the line's permission allows the request type. It can also report any matching tag regardless of permission, install a line into the first free way, or drop a line to the not-present state.

Each way holds a usage bit, a full line address and a permission state: not-present, read-only or read-write. A tag that matches only counts as a hit when the line is present. When an access finds a present line, the block reports a replacement touch with the set and the way to an external replacement tracker, even if the permission check then refuses the access. Every response is registered and appears one cycle after its request.

Top module: `perm_tag_dir`

## Requirements
- R1: The number of sets is CAP_BYTES / WAYS / LINE_BYTES, a power of two above one. The set index is the field of width log2(sets) that starts at bit IDX_LSB of the address. Lines that differ only outside that field compete for the same WAYS ways. `touch_set` carries that field.
- R2: A request on `req_valid` gives exactly one response with `rsp_valid` high in the next cycle. A cycle with no request gives `rsp_valid` and every other response flag low in the next cycle.
- R3: A request whose offset bits (below log2(LINE_BYTES)) are not zero is flagged with `rsp_error`. It gives no hit, no grant, no touch, `rsp_avail` low, and it changes no state.
- R4: `req_cmd` codes are 0 access, 1 probe, 2 allocate and 3 deallocate. An access hits only on a tag match whose permission is not not-present. A probe hits on any stored tag match, including a not-present line. On a hit, `rsp_way` gives the matching way.
- R5: Permission codes are 0 not-present, 1 read-only and 2 read-write. Request types are 0 load, 1 instruction fetch and 2 store, and code 3 is treated like a store. A read-write hit grants every type. A read-only hit grants only a load or a fetch, and still reports hit and way when it refuses.
- R6: Every access hit pulses `touch_valid` with `touch_set` and `touch_way`, whether or not the request is granted. Probe, allocate, deallocate and a miss give no touch.
- R7: `rsp_avail` is high when the indexed set has a way that holds the same line address in any state, a way that is empty, or a way that is not-present.
- R8: An accepted allocation writes the line with permission `req_perm` into the lowest-numbered way that is empty or not-present, and returns that way. Any other way still holding the same address as not-present is emptied.
- R9: An allocation is rejected with `rsp_error`, and changes nothing, when the line is already present, when the set has no empty or not-present way, or when `req_perm` is 0 or 3.
- R10: A deallocation sets a present matching line to not-present and keeps its tag, so a probe still finds it. A deallocation of an absent line changes nothing.
- R11: After reset every way of every set is empty, and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 2 | Command: 0 access, 1 probe, 2 allocate, 3 deallocate |
| req_addr | input | ADDR_W | Byte address of the line |
| req_type | input | 2 | Access type: 0 load, 1 fetch, 2 store |
| req_perm | input | 2 | Permission for an allocation: 1 read-only, 2 read-write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Tag found (present for access, allocate and deallocate; any state for probe) |
| rsp_granted | output | 1 | Access permitted by the line's permission |
| rsp_way | output | log2(WAYS) | Matching or allocated way |
| rsp_avail | output | 1 | Indexed set can take the line |
| rsp_error | output | 1 | Misaligned request or rejected allocation |
| touch_valid | output | 1 | Replacement touch strobe |
| touch_set | output | log2(sets) | Set of the touched line |
| touch_way | output | log2(WAYS) | Way of the touched line |

## Verification
The hardest state to reach is a set that holds one address twice, once as a live line and once as a stale not-present copy. Allocation prevents it by emptying the stale way. To test this, the bench fills a set and deallocates two adjacent ways. It then reallocates the address of the higher one, so the lowest open way is below the stale copy. A probe afterwards has to find the address only in the new way. A reference model in the bench tracks every way of every set, so each response field is predicted on the small eight-set, four-way configuration. The sweep covers all sets, ways and request types against both permission states.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [1:0] {
        CMD_ACCESS  = 2'd0,
        CMD_PROBE   = 2'd1,
        CMD_ALLOC   = 2'd2,
        CMD_DEALLOC = 2'd3
    } cmd_e;

    localparam logic [1:0] PERM_NONE = 2'd0;
    localparam logic [1:0] PERM_RO   = 2'd1;
    localparam logic [1:0] PERM_RW   = 2'd2;

    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_FETCH = 2'd1;

    // Read-write admits any request; read-only admits only reads.
    function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] kind);
        logic ok;
        ok = 1'b0;
        if (perm == PERM_RW)
            ok = 1'b1;
        else if (perm == PERM_RO)
            ok = (kind == KIND_LOAD) || (kind == KIND_FETCH);
        return ok;
    endfunction

    function automatic logic perm_is_valid_fill(input logic [1:0] perm);
        return (perm == PERM_RO) || (perm == PERM_RW);
    endfunction

    function automatic int unsigned sets_of(input int unsigned cap, input int unsigned ways,
                                            input int unsigned line);
        return (cap / ways) / line;
    endfunction

endpackage

// File: rtl/tagdir_store.sv
module tagdir_store #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_used,
    output logic [WAYS-1:0][1:0]         rd_perm,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic                         wr_used,
    input  logic [1:0]                   wr_perm,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic                         clr_en,
    input  logic [WAY_W-1:0]             clr_way
);
    import tagdir_pkg::*;

    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic             used_q [SETS][WAYS];
    logic [1:0]       perm_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    used_q[s][w] <= 1'b0;
                    perm_q[s][w] <= PERM_NONE;
                end
            end
        end else begin
            if (clr_en) begin
                used_q[rd_set][clr_way] <= 1'b0;
                perm_q[rd_set][clr_way] <= PERM_NONE;
            end
            if (wr_en) begin
                tag_q[rd_set][wr_way]  <= wr_tag;
                used_q[rd_set][wr_way] <= wr_used;
                perm_q[rd_set][wr_way] <= wr_perm;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w]  = tag_q[rd_set][w];
        assign rd_used[w] = used_q[rd_set][w];
        assign rd_perm[w] = perm_q[rd_set][w];
    end

endmodule

// File: rtl/tagdir_way_cmp.sv
module tagdir_way_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_used,
    input  logic [WAYS-1:0][1:0]       way_perm,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            any_vec,
    output logic [WAYS-1:0]            live_vec,
    output logic [WAYS-1:0]            open_vec
);
    import tagdir_pkg::*;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic same;
        logic absent;
        assign same        = way_used[w] && (way_tag[w] == look_tag);
        assign absent      = (way_perm[w] == PERM_NONE);
        assign any_vec[w]  = same;
        assign live_vec[w] = same && !absent;
        assign open_vec[w] = !way_used[w] || absent;
    end

endmodule

// File: rtl/tagdir_pick_low.sv
module tagdir_pick_low #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir #(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 4,
    parameter int WAYS       = 4,
    parameter int CAP_BYTES  = 128,
    parameter int IDX_LSB    = 2,
    localparam int SETS  = tagdir_pkg::sets_of(CAP_BYTES, WAYS, LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int TAG_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_type,
    input  logic [1:0]        req_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_granted,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_avail,
    output logic              rsp_error,
    output logic              touch_valid,
    output logic [SET_W-1:0]  touch_set,
    output logic [WAY_W-1:0]  touch_way
);
    import tagdir_pkg::*;

    cmd_e              cmd;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  line_tag;
    logic              misaligned;

    assign cmd        = cmd_e'(req_cmd);
    assign set_idx    = req_addr[IDX_LSB +: SET_W];
    assign line_tag   = req_addr[ADDR_W-1:OFF_W];
    assign misaligned = |req_addr[OFF_W-1:0];

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_used;
    logic [WAYS-1:0][1:0]       rd_perm;

    logic             wr_en, wr_used, clr_en;
    logic [WAY_W-1:0] wr_way, clr_way;
    logic [1:0]       wr_perm;

    tagdir_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_set  (set_idx),
        .rd_tag  (rd_tag),
        .rd_used (rd_used),
        .rd_perm (rd_perm),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_used (wr_used),
        .wr_perm (wr_perm),
        .wr_tag  (line_tag),
        .clr_en  (clr_en),
        .clr_way (clr_way)
    );

    logic [WAYS-1:0] any_vec, live_vec, open_vec;

    tagdir_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
        .way_tag  (rd_tag),
        .way_used (rd_used),
        .way_perm (rd_perm),
        .look_tag (line_tag),
        .any_vec  (any_vec),
        .live_vec (live_vec),
        .open_vec (open_vec)
    );

    logic             any_found, live_found, open_found;
    logic [WAY_W-1:0] any_idx, live_idx, open_idx;

    tagdir_pick_low #(.N(WAYS)) u_pick_any  (.vec(any_vec),  .found(any_found),  .idx(any_idx));
    tagdir_pick_low #(.N(WAYS)) u_pick_live (.vec(live_vec), .found(live_found), .idx(live_idx));
    tagdir_pick_low #(.N(WAYS)) u_pick_open (.vec(open_vec), .found(open_found), .idx(open_idx));

    logic             n_hit, n_grant, n_avail, n_err, n_touch, fill_ok;
    logic [WAY_W-1:0] n_way;

    always_comb begin
        n_hit   = 1'b0;
        n_grant = 1'b0;
        n_avail = 1'b0;
        n_err   = 1'b0;
        n_touch = 1'b0;
        n_way   = '0;
        fill_ok = 1'b0;
        wr_en   = 1'b0;
        wr_way  = '0;
        wr_used = 1'b0;
        wr_perm = PERM_NONE;
        clr_en  = 1'b0;
        clr_way = '0;
        if (req_valid) begin
            if (misaligned) begin
                n_err = 1'b1;
            end else begin
                n_avail = |(any_vec | open_vec);
                unique case (cmd)
                    CMD_ACCESS: begin
                        n_hit   = live_found;
                        n_way   = live_idx;
                        n_grant = live_found && perm_allows(rd_perm[live_idx], req_type);
                        n_touch = live_found;
                    end
                    CMD_PROBE: begin
                        n_hit = any_found;
                        n_way = any_idx;
                    end
                    CMD_ALLOC: begin
                        n_hit   = live_found;
                        fill_ok = !live_found && open_found && perm_is_valid_fill(req_perm);
                        n_err   = !fill_ok;
                        if (fill_ok) begin
                            n_way   = open_idx;
                            wr_en   = 1'b1;
                            wr_way  = open_idx;
                            wr_used = 1'b1;
                            wr_perm = req_perm;
                            // a stale not-present copy elsewhere is emptied
                            clr_en  = any_found && (any_idx != open_idx);
                            clr_way = any_idx;
                        end
                    end
                    CMD_DEALLOC: begin
                        n_hit = live_found;
                        n_way = live_idx;
                        if (live_found) begin
                            wr_en   = 1'b1;
                            wr_way  = live_idx;
                            wr_used = 1'b1;
                            wr_perm = PERM_NONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_granted <= 1'b0;
            rsp_way     <= '0;
            rsp_avail   <= 1'b0;
            rsp_error   <= 1'b0;
            touch_valid <= 1'b0;
            touch_set   <= '0;
            touch_way   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= n_hit;
            rsp_granted <= n_grant;
            rsp_way     <= n_way;
            rsp_avail   <= n_avail;
            rsp_error   <= n_err;
            touch_valid <= n_touch;
            touch_set   <= n_touch ? set_idx : '0;
            touch_way   <= n_touch ? n_way : '0;
        end
    end

endmodule

// File: rtl/perm_tag_dir_chk.sv
module perm_tag_dir_chk #(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 4,
    parameter int WAYS       = 4,
    parameter int CAP_BYTES  = 128,
    parameter int IDX_LSB    = 2,
    localparam int SETS  = tagdir_pkg::sets_of(CAP_BYTES, WAYS, LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_granted,
    input logic [WAY_W-1:0]  rsp_way,
    input logic              rsp_error,
    input logic              touch_valid,
    input logic [SET_W-1:0]  touch_set,
    input logic [WAY_W-1:0]  touch_way
);
    logic aligned_access;
    logic aligned_alloc;
    assign aligned_access = req_valid && (req_cmd == 2'd0) && !(|req_addr[OFF_W-1:0]);
    assign aligned_alloc  = req_valid && (req_cmd == 2'd2) && !(|req_addr[OFF_W-1:0]);

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_error && !touch_valid));

    assert_misalign_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && |req_addr[OFF_W-1:0]) |=> (rsp_error && !rsp_hit && !rsp_granted && !touch_valid));

    assert_grant_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_granted |-> rsp_hit);

    assert_touch_on_hit_R6: assert property (@(posedge clk) disable iff (rst)
        aligned_access |=> (touch_valid == rsp_hit));

    assert_touch_set_R1: assert property (@(posedge clk) disable iff (rst)
        aligned_access |=> (!touch_valid || touch_set == $past(req_addr[IDX_LSB +: SET_W])));

    assert_touch_way_R6: assert property (@(posedge clk) disable iff (rst)
        touch_valid |-> (rsp_hit && touch_way == rsp_way));

    assert_dup_alloc_rejected_R9: assert property (@(posedge clk) disable iff (rst)
        aligned_alloc |=> (!rsp_hit || rsp_error));

endmodule

bind perm_tag_dir perm_tag_dir_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WAYS(WAYS),
    .CAP_BYTES(CAP_BYTES), .IDX_LSB(IDX_LSB)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_cmd     (req_cmd),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_granted (rsp_granted),
    .rsp_way     (rsp_way),
    .rsp_error   (rsp_error),
    .touch_valid (touch_valid),
    .touch_set   (touch_set),
    .touch_way   (touch_way)
);

// File: tb/perm_tag_dir_bench.sv
module perm_tag_dir_bench;

    localparam int AW = 12;
    localparam int NS = 8;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cmd = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_type = 2'd0;
    logic [1:0]    req_perm = 2'd0;
    logic          rsp_valid, rsp_hit, rsp_granted, rsp_avail, rsp_error, touch_valid;
    logic [1:0]    rsp_way, touch_way;
    logic [2:0]    touch_set;

    perm_tag_dir #(.ADDR_W(AW), .LINE_BYTES(4), .WAYS(NW), .CAP_BYTES(128), .IDX_LSB(2))
    u_perm_tag_dir (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_type(req_type), .req_perm(req_perm),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_granted(rsp_granted),
        .rsp_way(rsp_way), .rsp_avail(rsp_avail), .rsp_error(rsp_error),
        .touch_valid(touch_valid), .touch_set(touch_set), .touch_way(touch_way)
    );

    always #5 clk = ~clk;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [9:0] m_tag  [NS][NW];
    bit         m_used [NS][NW];
    logic [1:0] m_perm [NS][NW];

    task automatic chk(input string rq, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int t, input int s);
        logic [6:0] th;
        logic [2:0] sh;
        th = t[6:0];
        sh = s[2:0];
        return {th, sh, 2'b00};
    endfunction

    // Reference model of R1..R10 over all ways of all sets.
    task automatic run(input logic [1:0] cmd, input logic [AW-1:0] addr,
                       input logic [1:0] typ, input logic [1:0] prm);
        int s, live, anyw, opn, e_way;
        bit mis, e_hit, e_gr, e_av, e_err, e_tch, ok;
        logic [9:0] tg;
        s = int'(addr[4:2]);
        tg = addr[11:2];
        mis = (addr[1:0] != 2'b00);
        live = -1; anyw = -1; opn = -1;
        for (int w = 0; w < NW; w++) begin
            if (m_used[s][w] && m_tag[s][w] == tg) begin
                anyw = w;
                if (m_perm[s][w] != 2'd0) live = w;
            end
            if ((!m_used[s][w] || m_perm[s][w] == 2'd0) && opn < 0) opn = w;
        end
        e_hit = 0; e_gr = 0; e_av = 0; e_err = 0; e_tch = 0; e_way = 0; ok = 0;
        if (mis) e_err = 1;
        else begin
            e_av = (anyw >= 0) || (opn >= 0);
            case (cmd)
                2'd0: if (live >= 0) begin
                    e_hit = 1; e_way = live; e_tch = 1;
                    e_gr = (m_perm[s][live] == 2'd2) ||
                           (m_perm[s][live] == 2'd1 && (typ == 2'd0 || typ == 2'd1));
                end
                2'd1: if (anyw >= 0) begin e_hit = 1; e_way = anyw; end
                2'd2: begin
                    e_hit = (live >= 0);
                    ok = (live < 0) && (opn >= 0) && (prm == 2'd1 || prm == 2'd2);
                    e_err = !ok;
                    if (ok) e_way = opn;
                end
                default: if (live >= 0) begin e_hit = 1; e_way = live; end
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_type = typ; req_perm = prm;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp_valid", int'(rsp_valid), 1);
        chk("R4 hit", int'(rsp_hit), int'(e_hit));
        chk("R5 granted", int'(rsp_granted), int'(e_gr));
        chk("R8 way", int'(rsp_way), e_way);
        chk("R7 avail", int'(rsp_avail), int'(e_av));
        chk("R9 error", int'(rsp_error), int'(e_err));
        chk("R6 touch", int'(touch_valid), int'(e_tch));
        if (e_tch) begin
            chk("R1 touch_set", int'(touch_set), s);
            chk("R6 touch_way", int'(touch_way), e_way);
        end
        if (!mis && cmd == 2'd2 && ok) begin
            m_used[s][opn] = 1; m_tag[s][opn] = tg; m_perm[s][opn] = prm;
            if (anyw >= 0 && anyw != opn) begin m_used[s][anyw] = 0; m_perm[s][anyw] = 2'd0; end
        end
        if (!mis && cmd == 2'd3 && live >= 0) m_perm[s][live] = 2'd0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_tag[s][w] = '0; m_used[s][w] = 0; m_perm[s][w] = 2'd0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: outputs quiet and all sets empty after reset
        chk("R11 rsp_valid", int'(rsp_valid), 0);
        chk("R11 touch", int'(touch_valid), 0);
        chk("R11 error", int'(rsp_error), 0);
        for (int s = 0; s < NS; s++) begin
            run(2'd1, mk(5, s), 2'd0, 2'd0);
            chk("R11 empty probe", int'(rsp_hit), 0);
        end
        // Fill every set; alternate read-only and read-write
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                run(2'd2, mk(w + 1, s), 2'd0, (w % 2 == 1) ? 2'd2 : 2'd1);
        // R9: full set and duplicate allocation are rejected
        for (int s = 0; s < NS; s++) run(2'd2, mk(9, s), 2'd0, 2'd2);
        run(2'd2, mk(1, 0), 2'd0, 2'd2);
        // Access sweep: all sets, ways and request types
        for (int s = 0; s < NS; s++)
            for (int t = 1; t <= NW; t++)
                for (int k = 0; k < 4; k++) run(2'd0, mk(t, s), 2'(k), 2'd0);
        // Misses: full set is unavailable to a new address (R7)
        for (int s = 0; s < NS; s++) run(2'd0, mk(20, s), 2'd0, 2'd0);
        // R10: deallocate way 2 of set 3
        run(2'd3, mk(3, 3), 2'd0, 2'd0);
        run(2'd0, mk(3, 3), 2'd0, 2'd0);
        chk("R10 access after dealloc", int'(rsp_hit), 0);
        run(2'd1, mk(3, 3), 2'd0, 2'd0);
        chk("R10 probe keeps tag", int'(rsp_way), 2);
        run(2'd2, mk(30, 3), 2'd0, 2'd2);
        chk("R8 lowest open way", int'(rsp_way), 2);
        // R8: stale copy above the lowest open way is emptied
        run(2'd3, mk(1, 3), 2'd0, 2'd0);
        run(2'd3, mk(2, 3), 2'd0, 2'd0);
        run(2'd2, mk(2, 3), 2'd0, 2'd1);
        chk("R8 realloc to way 0", int'(rsp_way), 0);
        run(2'd1, mk(2, 3), 2'd0, 2'd0);
        chk("R8 single copy", int'(rsp_way), 0);
        run(2'd2, mk(1, 3), 2'd0, 2'd2);
        chk("R8 emptied way reused", int'(rsp_way), 1);
        run(2'd3, mk(40, 3), 2'd0, 2'd0);
        // R3: misaligned access and allocation
        run(2'd0, mk(1, 0) | 12'd1, 2'd0, 2'd0);
        chk("R3 no touch", int'(touch_valid), 0);
        run(2'd0, mk(1, 0), 2'd0, 2'd0);
        run(2'd3, mk(2, 5) | 12'd2, 2'd0, 2'd0);
        run(2'd0, mk(2, 5), 2'd2, 2'd0);
        chk("R3 state unchanged", int'(rsp_granted), 1);
        // R9: bad permission code on allocation
        run(2'd3, mk(1, 6), 2'd0, 2'd0);
        run(2'd2, mk(60, 6), 2'd0, 2'd0);
        run(2'd2, mk(60, 6), 2'd0, 2'd3);
        run(2'd1, mk(60, 6), 2'd0, 2'd0);
        chk("R9 rejected leaves no line", int'(rsp_hit), 0);
        run(2'd2, mk(60, 6), 2'd0, 2'd2);
        run(2'd0, mk(60, 6), 2'd2, 2'd0);
        // R2: idle cycle gives no response
        @(negedge clk);
        chk("R2 idle", int'(rsp_valid), 0);
        report();
    end

endmodule